// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by walking a two-level tree of page tables held in memory. The virtual address is cut into three fields. The top 12 bits select an entry in a first-level table, and the start of that table comes from a root base input. That entry gives the 30-bit address of a second-level table. The next 8 bits select an entry in that second-level table, and the entry gives an 18-bit physical page number. The low 12 bits are the offset within the page and pass through unchanged.

A client offers a request with a valid/ready handshake. The walker then makes two reads, one after the other, through a single memory read port. The read port has a request handshake and a response strobe. When the second response arrives, the walker presents the physical address and pulses done for one cycle. Only one walk is in flight at a time. New requests are held off until the current walk finishes.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1, mem_rd_valid is 0 and done is 0.
- R2: The first read of a walk targets root_base + 4 × vaddr[31:20], taken modulo 2^30.
- R3: The second read targets T + 4 × vaddr[19:12], modulo 2^30. T is bits [29:0] of the first response word; bits [31:30] of that word have no effect.
- R4: The physical address is {W[17:0], vaddr[11:0]}, where W is the second response word. Bits [31:18] of W have no effect.
- R5: Each accepted request causes exactly two read handshakes, first-level then second-level. The second read is not issued before the first response has arrived.
- R6: done is high for exactly one cycle, in the cycle after the second response is sampled. The physical address is valid in that cycle.
- R7: req_ready is 0 from the cycle after a request is accepted until done. A request offered during a walk is accepted only after the earlier walk has completed.
- R8: While mem_rd_valid is 1 and mem_rd_ready is 0, the read request stays asserted and mem_rd_addr stays unchanged in the next cycle.
- R9: root_base and req_vaddr are captured when the request is accepted. Changing them during a walk does not alter that walk's reads or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 30 | Physical base of the first-level table |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 30 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned entry word |
| done | output | 1 | One-cycle pulse: translation complete |
| paddr | output | 30 | Translated physical address |

## Verification
The assertions check the following handshake rules on every cycle:
- the read request is held stable while the memory stalls;
- req_ready is low whenever a read is pending;
- done lasts a single cycle and always follows a response;
- an accepted request leads at once to a read request.

The bench scenarios cover the rest. They check the arithmetic of both read addresses, including wrap past the top of the 30-bit space. They check that the unused upper bits of each response word are discarded, and that exactly two ordered reads occur per walk. They also show that root_base and req_vaddr changes during a walk are ignored, and that back-to-back requests are serialised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE     = 3'd0,
        WALK_L1_ISSUE = 3'd1,
        WALK_L1_WAIT  = 3'd2,
        WALK_L2_ISSUE = 3'd3,
        WALK_L2_WAIT  = 3'd4
    } walk_state_e;

endpackage

// File: rtl/ptw_field_split.sv
module ptw_field_split #(
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    parameter int OFF_W    = 12,
    localparam int VA_W    = L1_IDX_W + L2_IDX_W + OFF_W
) (
    input  logic [VA_W-1:0]     vaddr,
    output logic [L1_IDX_W-1:0] dir_idx,
    output logic [L2_IDX_W-1:0] leaf_idx,
    output logic [OFF_W-1:0]    page_off
);

    localparam int LEAF_LO = OFF_W;
    localparam int DIR_LO  = OFF_W + L2_IDX_W;

    always_comb begin
        page_off = vaddr[OFF_W-1:0];
        leaf_idx = vaddr[LEAF_LO +: L2_IDX_W];
        dir_idx  = vaddr[DIR_LO +: L1_IDX_W];
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W        = 30,
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic                sel_leaf,
    input  logic [PA_W-1:0]     root_base,
    input  logic [PA_W-1:0]     leaf_base,
    input  logic [L1_IDX_W-1:0] dir_idx,
    input  logic [L2_IDX_W-1:0] leaf_idx,
    output logic [PA_W-1:0]     rd_addr
);

    localparam int DIR_PAD  = PA_W - L1_IDX_W - ENTRY_SHIFT;
    localparam int LEAF_PAD = PA_W - L2_IDX_W - ENTRY_SHIFT;

    logic [PA_W-1:0] dir_ofs;
    logic [PA_W-1:0] leaf_ofs;
    logic [PA_W-1:0] base_sel;
    logic [PA_W-1:0] ofs_sel;

    generate
        if (ENTRY_SHIFT > 0) begin : g_scaled
            assign dir_ofs  = {{DIR_PAD{1'b0}}, dir_idx, {ENTRY_SHIFT{1'b0}}};
            assign leaf_ofs = {{LEAF_PAD{1'b0}}, leaf_idx, {ENTRY_SHIFT{1'b0}}};
        end else begin : g_unscaled
            assign dir_ofs  = {{DIR_PAD{1'b0}}, dir_idx};
            assign leaf_ofs = {{LEAF_PAD{1'b0}}, leaf_idx};
        end
    endgenerate

    always_comb begin
        base_sel = sel_leaf ? leaf_base : root_base;
        ofs_sel  = sel_leaf ? leaf_ofs : dir_ofs;
        rd_addr  = base_sel + ofs_sel;
    end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int PA_W     = 30,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    parameter int OFF_W    = 12,
    parameter int PPN_W    = 18,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PA_W-1:0]     root_in,
    input  logic [L1_IDX_W-1:0] dir_idx_in,
    input  logic [L2_IDX_W-1:0] leaf_idx_in,
    input  logic [OFF_W-1:0]    off_in,
    input  logic                mem_rd_ready,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    output logic                req_ready,
    output logic                rd_valid,
    output logic                sel_leaf,
    output logic [PA_W-1:0]     root_q_o,
    output logic [PA_W-1:0]     leaf_base_o,
    output logic [L1_IDX_W-1:0] dir_idx_o,
    output logic [L2_IDX_W-1:0] leaf_idx_o,
    output logic                done,
    output logic [PPN_W+OFF_W-1:0] paddr
);

    localparam int PADDR_W = PPN_W + OFF_W;

    typedef struct packed {
        walk_state_e            state;
        logic [PA_W-1:0]        root;
        logic [L1_IDX_W-1:0]    dir_idx;
        logic [L2_IDX_W-1:0]    leaf_idx;
        logic [OFF_W-1:0]       off;
        logic [PA_W-1:0]        leaf_base;
        logic [PADDR_W-1:0]     paddr;
        logic                   done;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic unused_word_hi;
    assign unused_word_hi = ^mem_rsp_data[WORD_W-1:PA_W];

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    walk_d.root     = root_in;
                    walk_d.dir_idx  = dir_idx_in;
                    walk_d.leaf_idx = leaf_idx_in;
                    walk_d.off      = off_in;
                    walk_d.state    = WALK_L1_ISSUE;
                end
            end
            WALK_L1_ISSUE: begin
                if (mem_rd_ready) walk_d.state = WALK_L1_WAIT;
            end
            WALK_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.leaf_base = mem_rsp_data[PA_W-1:0];
                    walk_d.state     = WALK_L2_ISSUE;
                end
            end
            WALK_L2_ISSUE: begin
                if (mem_rd_ready) walk_d.state = WALK_L2_WAIT;
            end
            WALK_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.paddr = {mem_rsp_data[PPN_W-1:0], walk_q.off};
                    walk_d.done  = 1'b1;
                    walk_d.state = WALK_IDLE;
                end
            end
            default: walk_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{
                state:     WALK_IDLE,
                root:      '0,
                dir_idx:   '0,
                leaf_idx:  '0,
                off:       '0,
                leaf_base: '0,
                paddr:     '0,
                done:      1'b0
            };
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        req_ready   = (walk_q.state == WALK_IDLE);
        rd_valid    = (walk_q.state == WALK_L1_ISSUE) || (walk_q.state == WALK_L2_ISSUE);
        sel_leaf    = (walk_q.state == WALK_L2_ISSUE);
        root_q_o    = walk_q.root;
        leaf_base_o = walk_q.leaf_base;
        dir_idx_o   = walk_q.dir_idx;
        leaf_idx_o  = walk_q.leaf_idx;
        done        = walk_q.done;
        paddr       = walk_q.paddr;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int OFF_W       = 12,
    parameter int PA_W        = 30,
    parameter int PPN_W       = 18,
    parameter int WORD_W      = 32,
    parameter int ENTRY_SHIFT = 2,
    localparam int VA_W       = L1_IDX_W + L2_IDX_W + OFF_W,
    localparam int PADDR_W    = PPN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PA_W-1:0]    root_base,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               done,
    output logic [PADDR_W-1:0] paddr
);

    logic [L1_IDX_W-1:0] in_dir_idx;
    logic [L2_IDX_W-1:0] in_leaf_idx;
    logic [OFF_W-1:0]    in_off;
    logic [L1_IDX_W-1:0] cur_dir_idx;
    logic [L2_IDX_W-1:0] cur_leaf_idx;
    logic [PA_W-1:0]     cur_root;
    logic [PA_W-1:0]     cur_leaf_base;
    logic                sel_leaf;

    ptw_field_split #(
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W),
        .OFF_W    (OFF_W)
    ) u_split (
        .vaddr    (req_vaddr),
        .dir_idx  (in_dir_idx),
        .leaf_idx (in_leaf_idx),
        .page_off (in_off)
    );

    ptw_fsm #(
        .PA_W     (PA_W),
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W),
        .OFF_W    (OFF_W),
        .PPN_W    (PPN_W),
        .WORD_W   (WORD_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .root_in       (root_base),
        .dir_idx_in    (in_dir_idx),
        .leaf_idx_in   (in_leaf_idx),
        .off_in        (in_off),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .req_ready     (req_ready),
        .rd_valid      (mem_rd_valid),
        .sel_leaf      (sel_leaf),
        .root_q_o      (cur_root),
        .leaf_base_o   (cur_leaf_base),
        .dir_idx_o     (cur_dir_idx),
        .leaf_idx_o    (cur_leaf_idx),
        .done          (done),
        .paddr         (paddr)
    );

    ptw_addr_gen #(
        .PA_W        (PA_W),
        .L1_IDX_W    (L1_IDX_W),
        .L2_IDX_W    (L2_IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .sel_leaf  (sel_leaf),
        .root_base (cur_root),
        .leaf_base (cur_leaf_base),
        .dir_idx   (cur_dir_idx),
        .leaf_idx  (cur_leaf_idx),
        .rd_addr   (mem_rd_addr)
    );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int PA_W = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rsp_valid,
    input logic            done
);

    AST_STALL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid)); // R6

    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_valid && !req_ready)); // R5

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !mem_rd_valid)); // R7

endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [29:0] root_base;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [29:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [29:0] paddr;

    always #2 clk = ~clk;

    pt_walker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .root_base     (root_base),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .paddr         (paddr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    int done_cnt = 0;
    int rd_count = 0;
    int cyc = 0;
    int lat_cnt = 0;
    bit stall_mode = 1'b0;
    bit stall_seen = 1'b0;
    bit prev_done = 1'b0;
    logic [29:0] stall_addr;
    logic [29:0] pend_addr;

    logic [29:0] exp_addr_q[$];
    string       exp_tag_q[$];
    logic [29:0] exp_pa_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [29:0] a);
        return ({2'b00, a} * 32'h9E37_79B1) ^ 32'hC3A5_0000;
    endfunction

    // memory model: accepts reads, returns data after a short varying latency
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            lat_cnt       = 0;
            stall_seen    = 1'b0;
        end else begin
            cyc++;
            mem_rsp_valid = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(pend_addr);
                end
            end
            if (stall_seen) begin
                check(mem_rd_valid && (mem_rd_addr == stall_addr), "R8",
                      {1'b0, mem_rd_valid, mem_rd_addr}, {2'b01, stall_addr});
                stall_seen = 1'b0;
            end
            mem_rd_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (mem_rd_valid) begin
                if (mem_rd_ready) begin
                    string       tag;
                    logic [29:0] ea;
                    check(lat_cnt == 0 && !mem_rsp_valid, "R5 read while response pending",
                          lat_cnt, 0);
                    if (exp_addr_q.size() == 0) begin
                        check(1'b0, "R5 unexpected read", {2'b00, mem_rd_addr}, 0);
                    end else begin
                        ea  = exp_addr_q.pop_front();
                        tag = exp_tag_q.pop_front();
                        check(mem_rd_addr == ea, tag, {2'b00, mem_rd_addr}, {2'b00, ea});
                    end
                    rd_count++;
                    pend_addr = mem_rd_addr;
                    lat_cnt   = 1 + (cyc % 3);
                end else begin
                    stall_seen = 1'b1;
                    stall_addr = mem_rd_addr;
                end
            end
        end
    end

    // result monitor: pops the scoreboard on each done
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!done, "R6 done longer than one cycle", {31'd0, done}, 0);
            if (done) begin
                logic [29:0] epa;
                if (exp_pa_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", {2'b00, paddr}, 0);
                end else begin
                    epa = exp_pa_q.pop_front();
                    check(paddr == epa, "R4 physical address", {2'b00, paddr}, {2'b00, epa});
                end
                check(rd_count == 2, "R5 reads per walk", rd_count, 2);
                rd_count = 0;
                done_cnt++;
            end
            prev_done = done;
        end
    end

    task automatic send(input logic [31:0] va, input logic [29:0] root);
        logic [29:0] l1a, tbl, l2a, pa;
        logic [31:0] w2;
        l1a = root + {16'd0, va[31:20], 2'b00};
        tbl = mem_word(l1a)[29:0];
        l2a = tbl + {20'd0, va[19:12], 2'b00};
        w2  = mem_word(l2a);
        pa  = {w2[17:0], va[11:0]};
        exp_addr_q.push_back(l1a); exp_tag_q.push_back("R2 first-level address");
        exp_addr_q.push_back(l2a); exp_tag_q.push_back("R3 second-level address");
        exp_pa_q.push_back(pa);
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = root;
        while (!req_ready) @(negedge clk);
        #1;
        check(done_cnt == acc_cnt, "R7 accepted before prior walk finished", done_cnt, acc_cnt);
        acc_cnt++;
        @(negedge clk);
        check(!req_ready, "R7 ready during walk", {31'd0, req_ready}, 0);
        req_valid = 1'b0;
        root_base = ~root;   // R9: must not disturb the walk in flight
        req_vaddr = ~va;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        root_base = '0;
        repeat (3) @(negedge clk);
        check(req_ready && !mem_rd_valid && !done, "R1 reset state",
              {29'd0, req_ready, mem_rd_valid, done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_rd_valid && !done, "R1 after reset",
              {29'd0, req_ready, mem_rd_valid, done}, 32'h4);

        // back-to-back requests, memory always ready
        send(32'h0000_0000, 30'h0001_0000);
        send(32'hFFFF_FFFF, 30'h0002_0000);
        send(32'h1234_5678, 30'h0100_0000);
        send(32'h8001_2ABC, 30'h2000_4000);
        // R2 wrap: root near top of the 30-bit space
        send(32'hFFF0_0123, 30'h3FFF_FFF0);
        send(32'h0010_1FFF, 30'h3FFF_FFFC);

        // memory stalls the read request
        stall_mode = 1'b1;
        send(32'hDEAD_BEEF, 30'h0003_3000);
        send(32'h0ABC_DEF0, 30'h1555_5554);
        send(32'h7FF8_0800, 30'h0000_0004);
        stall_mode = 1'b0;

        // idle gap, then a lone request
        repeat (5) @(negedge clk);
        send(32'hCAFE_F00D, 30'h0ACE_0000);

        while (done_cnt < acc_cnt) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_addr_q.size() == 0, "R5 reads left unissued", exp_addr_q.size(), 0);
        check(exp_pa_q.size() == 0, "R6 results missing", exp_pa_q.size(), 0);
        check(req_ready && !done, "R6 idle after last walk", {30'd0, req_ready, done}, 32'h2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule